// File: doc/BRIEF.md
# Repeated-Addition Multiply-Add Unit

This unit computes `(4*a + b) mod 16` for two 4-bit unsigned operands. It does not use a multiplier. A 4-bit accumulator is first loaded with `b`. The operand `a` is then added into the accumulator four times through a ripple-carry adder. A small modulo-4 counter tracks how many additions have been made. A two-bit control state machine sequences the work with three strobes: load the accumulator from `b`, load it from the adder sum, and advance the counter. The state machine ends the addition phase when the counter raises its terminal flag.

The caller holds `a` and `b` steady and pulses `start_i` while the unit is idle. Five clock edges after the start is accepted, `done_o` is high for exactly one cycle, and `x_o` carries the result at that point. The accumulator keeps the result while the unit is idle, until the next accepted start. A start request seen while a computation is running is ignored. The operand width and the number of additions are parameters. The defaults are 4 bits and 4 additions.

Top module: `mul_add_seq`

## Requirements
- R1: While reset is asserted and after it is released, `x_o` is 0 and `done_o` is 0, and the unit is idle with its addition counter at 0.
- R2: A high `start_i` sampled in idle moves the unit to a load step. At the next edge `x_o` takes the value of `b_i`.
- R3: After the load, each of the following four clock edges sets `x_o` to the previous `x_o` plus `a_i`, truncated to 4 bits. No further additions follow.
- R4: `done_o` goes high for exactly one cycle, on the fifth edge after the accepted start. At that point `x_o` equals `(4*a_i + b_i) mod 16`.
- R5: When `done_o` is high the addition counter is back at 0, so that a following run also performs exactly four additions.
- R6: A high `start_i` while the unit is loading, adding or signalling done has no effect. The run continues with unchanged timing, and no new load follows it.
- R7: While idle with `start_i` low, `x_o` holds its last value, even if `b_i` or `a_i` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 4 | Operand added repeatedly |
| b_i | input | 4 | Operand loaded first |
| start_i | input | 1 | Start request, sampled in idle |
| x_o | output | 4 | Accumulator value |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench applies all 256 `(a, b)` pairs back to back. It tracks `x_o` after the load and after every single addition, so the per-step checks separate a wrong load source from a wrong adder or carry bit, and from a wrong number of additions. Pairs with `a` at 0, 1, 8 and 15 test wraparound and carry at the top bit, and runs that follow each other directly show whether the counter restarts at 0. For a subset of pairs, `start_i` is raised in the middle of the addition phase and again during the done cycle, with `b_i` changed at the same time. This shows whether a busy-time start restarts the run or causes an extra load.

// File: rtl/mul_add_pkg.sv
package mul_add_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOAD = 2'b01,
    ST_ADD  = 2'b11,
    ST_DONE = 2'b10
  } state_e;
endpackage

// File: rtl/mul_add_adder.sv
module mul_add_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = x_i[i] ^ y_i[i] ^ carry[i];
    assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
  end

  // top carry dropped: modulo 2^W
  logic unused_carry;
  assign unused_carry = carry[W];
endmodule

// File: rtl/mul_add_acc.sv
module mul_add_acc #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_b_i,
  input  logic         ld_sum_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] x_o
);
  logic [W-1:0] x_q, sum;

  mul_add_adder #(.W(W)) u_add (
    .x_i  (x_q),
    .y_i  (a_i),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       x_q <= '0;
    else if (ld_b_i)   x_q <= b_i;
    else if (ld_sum_i) x_q <= sum;
  end

  assign x_o = x_q;

  assert_load_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_b_i |=> x_q == $past(b_i));

  assert_add_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_sum_i && !ld_b_i) |=> x_q == W'($past(x_q) + $past(a_i)));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_b_i && !ld_sum_i) |=> $stable(x_q));
endmodule

// File: rtl/mul_add_cnt.sv
module mul_add_cnt #(
  parameter int MOD   = 4,
  localparam int CW   = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic          term_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign term_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && term_o) |=> cnt_q == '0);

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/mul_add_ctrl.sv
module mul_add_ctrl
  import mul_add_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic term_i,
  output logic ld_b_o,
  output logic ld_sum_o,
  output logic inc_o,
  output logic done_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_ADD;
      ST_ADD:  if (term_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // Moore strobes
  assign ld_b_o   = (state_q == ST_LOAD);
  assign ld_sum_o = (state_q == ST_ADD);
  assign inc_o    = (state_q == ST_ADD);
  assign done_o   = (state_q == ST_DONE);

  assert_load_only_from_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> state_q != ST_LOAD);

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> ld_b_o);

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_b_o, ld_sum_o, done_o}));
endmodule

// File: rtl/mul_add_seq.sv
module mul_add_seq #(
  parameter int W    = 4,
  parameter int ADDS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         start_i,
  output logic [W-1:0] x_o,
  output logic         done_o
);
  localparam int CW = (ADDS > 2) ? $clog2(ADDS) : 1;

  logic ld_b, ld_sum, inc, term;
  logic [CW-1:0] cnt;

  mul_add_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .term_i  (term),
    .ld_b_o  (ld_b),
    .ld_sum_o(ld_sum),
    .inc_o   (inc),
    .done_o  (done_o)
  );

  mul_add_cnt #(.MOD(ADDS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .term_o(term),
    .cnt_o (cnt)
  );

  mul_add_acc #(.W(W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_b_i  (ld_b),
    .ld_sum_i(ld_sum),
    .a_i     (a_i),
    .b_i     (b_i),
    .x_o     (x_o)
  );

  assert_done_cnt_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt == '0);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (x_o == '0 && !done_o && cnt == '0));
endmodule

// File: tb/tb_mul_add_seq.sv
module tb_mul_add_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic start_i = 1'b0;
  logic [W-1:0] x_o;
  logic done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_add_seq #(.W(W), .ADDS(4)) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .start_i(start_i),
    .x_o    (x_o),
    .done_o (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One run; inputs driven and outputs sampled on the falling edge.
  task automatic run(input int ia, input int ib, input bit poke);
    logic [W-1:0] exp;
    logic [W-1:0] res;
    res = W'(ia * 4 + ib);
    a_i = W'(ia); b_i = W'(ib); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, "R4 done low during load", int'(done_o), 0);
    @(negedge clk);
    check(x_o == W'(ib), "R2 load of b", int'(x_o), ib);
    for (int k = 1; k <= 4; k++) begin
      if (poke && k == 2) start_i = 1'b1;   // R6: busy-time start
      @(negedge clk);
      start_i = 1'b0;
      exp = W'(ib + k * ia);
      check(x_o == exp, "R3 add step", int'(x_o), int'(exp));
      check(done_o == (k == 4), "R4 done timing", int'(done_o), int'(k == 4));
    end
    check(x_o == res, "R4 final result", int'(x_o), int'(res));
    if (poke) begin
      start_i = 1'b1; b_i = ~b_i;          // R6: start during done cycle
    end
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, "R4 done one cycle", int'(done_o), 0);
    if (poke) begin
      b_i = W'(ib + 3); a_i = W'(ia + 5);
      repeat (3) @(negedge clk);
      check(x_o == res && !done_o, "R6 no restart after busy start", int'(x_o), int'(res));
    end
    check(x_o == res, "R7 hold in idle", int'(x_o), int'(res));
  endtask

  initial begin
    #1;
    check(x_o == '0 && done_o == 1'b0, "R1 during reset", int'(x_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(x_o == '0 && done_o == 1'b0, "R1 after reset", int'(x_o), 0);
    // R5: back-to-back runs rely on the counter restarting at 0
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        run(ia, ib, ((ia + ib) % 5) == 0);
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule